// File: doc/BRIEF.md
# Multiplexed Burst Local-Bus Master

This block runs accesses on a 32-bit local bus whose address and data share the same wires. A request port carries a word address, a read/write flag, a beat count and up to four write words. The block accepts a request only while it is idle. It then drives one address cycle followed by one to four data cycles, and it completes one access before it starts the next.

In the address cycle, bits 31:2 of the bus carry the word address and bits 1:0 carry the beat count. During this cycle the block drives an active-low address strobe and an active-high address latch enable. In each data cycle the block drives write data or releases the bus for read data. It marks the final beat with an active-low last-beat strobe. An active-low ready input adds wait states. Read beats come back on a response port with their beat index, and a one-cycle done pulse closes each access.

The pads are modelled as separate bus output, output-enable and input vectors. Successive beats belong to consecutive word addresses starting at the address given. The bus carries that address only once, in the address cycle.

Top module: `mbus_master`

## Requirements
- R1: While reset (synchronous, active high) is held and in the cycle after it drops, `ads_n`=1, `blast_n`=1, `ale`=0, `bus_oe`=0, `bus_out`=0, `rsp_valid`=0, `done`=0 and `req_ready`=1.
- R2: `req_ready` is 1 only while idle. A request is taken at an edge where `req_valid` and `req_ready` are both 1, and the address cycle appears in the next cycle. While the block is busy, `req_valid` has no effect.
- R3: The address cycle lasts exactly one clock. In it `ads_n`=0, `ale`=1, `bus_oe`=1 and `bus_out` = {req_addr, req_len}. `req_len` is the beat count minus one: 00 gives 1 beat, 01 gives 2, 10 gives 3 and 11 gives 4.
- R4: From the first data cycle to the end of the access, `ads_n`=1 and `ale`=0.
- R5: `blast_n` is 0 during the final data beat, including any wait states in it. It is 1 on every earlier beat and goes back to 1 in the cycle after the final beat completes.
- R6: A beat completes only at an edge where `rdy_n` is sampled 0. Otherwise `bus_out`, `bus_oe`, `blast_n` and the beat position all hold.
- R7: For a write, beat k drives `bus_oe`=1 and `bus_out` = word k of `req_wdata`, which is bits [32k+31:32k].
- R8: For a read, `bus_oe`=0 in every data cycle. Each completed beat k gives a one-cycle `rsp_valid` in the next cycle, with `rsp_data` = `bus_in` sampled at the completing edge and `rsp_beat`=k. Writes never raise `rsp_valid`.
- R9: `done` pulses for one cycle, in the cycle after the final beat completes, for both reads and writes.
- R10: After an access, the idle bus keeps `bus_oe`=1 and `bus_out[1:0]` equal to that access's `req_len`. `bus_out[31:2]` holds the last write word's bits 31:2 after a write, or the address after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 30 | Word address of first beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Beat count minus one |
| req_wdata | input | 128 | Write words, word k at bits [32k+31:32k] |
| bus_out | output | 32 | Multiplexed bus driven value |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 32 | Multiplexed bus sampled value |
| ads_n | output | 1 | Address strobe, active low |
| ale | output | 1 | Address latch enable, active high |
| blast_n | output | 1 | Last-beat strobe, active low |
| rdy_n | input | 1 | Ready, active low |
| rsp_valid | output | 1 | Read beat returned |
| rsp_data | output | 32 | Read data |
| rsp_beat | output | 2 | Index of returned beat |
| done | output | 1 | Access finished pulse |

## Verification
Every output is registered. The address cycle appears one cycle after the accepting edge, and the first data beat appears one cycle after that. A read response and the `done` pulse appear one cycle after the edge at which `rdy_n` was low. The bench model updates at each rising edge from the inputs sampled there, and every output is compared at the following falling edge, so each check lands on exactly the cycle in which a result is due. The stimulus mixes random wait states, a long stall on the last beat, and requests held valid while the block is busy.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } mbus_state_e;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
   import mbus_pkg::*;
#(
   parameter int MAX_BEATS = 4,
   localparam int CNT_W = $clog2(MAX_BEATS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] req_len,
   input  logic             req_write,
   input  logic             rdy_n,
   output mbus_state_e      state,
   output logic [CNT_W-1:0] beat,
   output logic [CNT_W-1:0] len_q,
   output logic             wr_q,
   output logic             fire,
   output logic             last,
   output logic             ads_n,
   output logic             ale,
   output logic             blast_n,
   output logic             done
);
   logic [CNT_W-1:0] beat_nx;

   assign fire    = (state == ST_DATA) && !rdy_n;
   assign last    = (beat == len_q);
   assign beat_nx = beat + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         beat    <= '0;
         len_q   <= '0;
         wr_q    <= 1'b0;
         ads_n   <= 1'b1;
         ale     <= 1'b0;
         blast_n <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               state <= ST_ADDR;
               ads_n <= 1'b0;
               ale   <= 1'b1;
               len_q <= req_len;
               wr_q  <= req_write;
               beat  <= '0;
            end
            ST_ADDR: begin
               state   <= ST_DATA;
               ads_n   <= 1'b1;
               ale     <= 1'b0;
               blast_n <= (len_q != '0);
            end
            ST_DATA: if (fire) begin
               if (last) begin
                  state   <= ST_IDLE;
                  blast_n <= 1'b1;
                  done    <= 1'b1;
               end else begin
                  beat    <= beat_nx;
                  blast_n <= (beat_nx != len_q);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_strobe_pair_R3: assert property (@(posedge clk) disable iff (rst)
      !ads_n |-> (ale && state == ST_ADDR));
   assert_addr_single_R4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_ADDR) |=> (ads_n && !ale && state == ST_DATA));
   assert_blast_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DATA && !blast_n && rdy_n) |=> !blast_n);
   assert_wait_beat_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DATA && rdy_n) |=> ($stable(beat) && state == ST_DATA));
   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> (blast_n && state == ST_IDLE && $past(!blast_n)));
endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
   import mbus_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MAX_BEATS = 4,
   localparam int CNT_W  = $clog2(MAX_BEATS),
   localparam int ADDR_W = DATA_W - CNT_W
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        accept,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [CNT_W-1:0]            req_len,
   input  logic [MAX_BEATS*DATA_W-1:0] req_wdata,
   input  mbus_state_e                 state,
   input  logic [CNT_W-1:0]            beat,
   input  logic [CNT_W-1:0]            len_q,
   input  logic                        wr_q,
   input  logic                        fire,
   input  logic                        last,
   input  logic [DATA_W-1:0]           bus_in,
   output logic [DATA_W-1:0]           bus_out,
   output logic                        bus_oe,
   output logic                        rsp_valid,
   output logic [DATA_W-1:0]           rsp_data,
   output logic [CNT_W-1:0]            rsp_beat
);
   logic [DATA_W-1:0] req_words [MAX_BEATS];
   logic [DATA_W-1:0] wbuf      [MAX_BEATS];
   logic [CNT_W-1:0]  beat_nx;

   assign beat_nx = beat + CNT_W'(1);

   for (genvar i = 0; i < MAX_BEATS; i++) begin : g_word
      assign req_words[i] = req_wdata[i*DATA_W +: DATA_W];
      always_ff @(posedge clk) begin
         if (rst)         wbuf[i] <= '0;
         else if (accept) wbuf[i] <= req_words[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_out   <= '0;
         bus_oe    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_beat  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (accept) begin
            bus_out <= {req_addr, req_len};
            bus_oe  <= 1'b1;
         end
         if (state == ST_ADDR) begin
            bus_oe <= wr_q;
            if (wr_q) bus_out <= wbuf[0];
         end
         if (fire) begin
            if (!wr_q) begin
               rsp_valid <= 1'b1;
               rsp_data  <= bus_in;
               rsp_beat  <= beat;
            end
            if (last) begin
               bus_out <= {bus_out[DATA_W-1:CNT_W], len_q};
               bus_oe  <= 1'b1;
            end else if (wr_q) begin
               bus_out <= wbuf[beat_nx];
            end
         end
      end
   end

   assert_read_release_R8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DATA && !wr_q) |-> !bus_oe);
   assert_write_drive_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DATA && wr_q) |-> bus_oe);
   assert_bus_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DATA && !fire) |=> ($stable(bus_out) && $stable(bus_oe)));
   assert_no_write_rsp_R8: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid) |-> !wr_q);
endmodule

// File: rtl/mbus_master.sv
module mbus_master
   import mbus_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MAX_BEATS = 4,
   localparam int CNT_W  = $clog2(MAX_BEATS),
   localparam int ADDR_W = DATA_W - CNT_W
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic                        req_write,
   input  logic [CNT_W-1:0]            req_len,
   input  logic [MAX_BEATS*DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0]           bus_out,
   output logic                        bus_oe,
   input  logic [DATA_W-1:0]           bus_in,
   output logic                        ads_n,
   output logic                        ale,
   output logic                        blast_n,
   input  logic                        rdy_n,
   output logic                        rsp_valid,
   output logic [DATA_W-1:0]           rsp_data,
   output logic [CNT_W-1:0]            rsp_beat,
   output logic                        done
);
   initial begin
      assert (MAX_BEATS >= 2 && (1 << CNT_W) == MAX_BEATS)
         else $error("MAX_BEATS must be a power of two, at least 2");
      assert (DATA_W > CNT_W)
         else $error("DATA_W must exceed the size field width");
   end

   mbus_state_e      state;
   logic [CNT_W-1:0] beat, len_q;
   logic             wr_q, fire, last, accept;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   mbus_seq #(.MAX_BEATS(MAX_BEATS)) seq_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
      .req_write(req_write), .rdy_n(rdy_n), .state(state), .beat(beat),
      .len_q(len_q), .wr_q(wr_q), .fire(fire), .last(last),
      .ads_n(ads_n), .ale(ale), .blast_n(blast_n), .done(done)
   );

   mbus_datapath #(.DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) dp_i (
      .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
      .req_len(req_len), .req_wdata(req_wdata), .state(state), .beat(beat),
      .len_q(len_q), .wr_q(wr_q), .fire(fire), .last(last), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_beat(rsp_beat)
   );

   assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> (!ads_n && !req_ready));
   assert_addr_field_R3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> (bus_out == {$past(req_addr), $past(req_len)} && bus_oe));
endmodule

// File: tb/mbus_master_tb.sv
module mbus_master_tb_top;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [29:0]  req_addr = '0;
   logic         req_write = 1'b0;
   logic [1:0]   req_len = '0;
   logic [127:0] req_wdata = '0;
   logic [31:0]  bus_out, bus_in = '0, rsp_data;
   logic         bus_oe, ads_n, ale, blast_n, rdy_n = 1'b1, rsp_valid, done;
   logic [1:0]   rsp_beat;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbus_master dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
      .req_wdata(req_wdata), .bus_out(bus_out), .bus_oe(bus_oe),
      .bus_in(bus_in), .ads_n(ads_n), .ale(ale), .blast_n(blast_n),
      .rdy_n(rdy_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_beat(rsp_beat), .done(done)
   );

   // behavioural reference model
   int          ph = 0;      // 0 idle, 1 address, 2 data
   int          bt = 0, ln = 0;
   bit          wr = 0, waited = 0, used = 0, in_rst = 1;
   logic [31:0] wd [4];
   logic [31:0] e_bus = '0, e_rd = '0;
   logic        e_oe = 0, e_ads = 1, e_ale = 0, e_blast = 1, e_rv = 0, e_done = 0;
   logic [1:0]  e_rb = '0;

   always @(posedge clk) begin
      if (rst) begin
         ph = 0; bt = 0; e_bus = '0; e_oe = 0; e_ads = 1; e_ale = 0;
         e_blast = 1; e_rv = 0; e_done = 0; e_rd = '0; e_rb = '0;
         in_rst = 1; used = 0; waited = 0;
      end else begin
         in_rst = 0; e_rv = 0; e_done = 0; waited = 0;
         if (ph == 0) begin
            if (req_valid) begin
               ph = 1; e_ads = 0; e_ale = 1; ln = int'(req_len); wr = req_write;
               for (int k = 0; k < 4; k++) wd[k] = req_wdata[32*k +: 32];
               e_bus = {req_addr, req_len}; e_oe = 1; bt = 0; used = 1;
            end
         end else if (ph == 1) begin
            ph = 2; e_ads = 1; e_ale = 0; e_blast = (ln == 0) ? 1'b0 : 1'b1;
            e_oe = wr;
            if (wr) e_bus = wd[0];
         end else begin
            if (rdy_n) waited = 1;
            else begin
               if (!wr) begin e_rv = 1; e_rd = bus_in; e_rb = 2'(bt); end
               if (bt == ln) begin
                  ph = 0; e_blast = 1; e_done = 1; e_oe = 1;
                  e_bus = {e_bus[31:2], 2'(ln)};
               end else begin
                  bt++;
                  e_blast = (bt == ln) ? 1'b0 : 1'b1;
                  if (wr) e_bus = wd[bt];
               end
            end
         end
      end
   end

   task automatic chk(string tag, string nm, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: got %h expected %h", tag, nm, $time, got, exp);
      end
   endtask

   always @(negedge clk) begin
      string tb_, ts_;
      tb_ = in_rst ? "R1" : "R5";
      ts_ = in_rst ? "R1" : (ph == 0 && used) ? "R10" : waited ? "R6" : (ph == 1) ? "R3" : "R7";
      chk(in_rst ? "R1" : "R2", "req_ready", 32'(req_ready), 32'(ph == 0));
      chk(in_rst ? "R1" : "R3", "ads_n", 32'(ads_n), 32'(e_ads));
      chk(in_rst ? "R1" : "R4", "ale", 32'(ale), 32'(e_ale));
      chk(tb_, "blast_n", 32'(blast_n), 32'(e_blast));
      chk(in_rst ? "R1" : (ph == 2 && !wr) ? "R8" : ts_, "bus_oe", 32'(bus_oe), 32'(e_oe));
      chk(ts_, "bus_out", bus_out, e_bus);
      chk(in_rst ? "R1" : "R8", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) begin
         chk("R8", "rsp_data", rsp_data, e_rd);
         chk("R8", "rsp_beat", 32'(rsp_beat), 32'(e_rb));
      end
      chk(in_rst ? "R1" : "R9", "done", 32'(done), 32'(e_done));
   end

   int wait_pct = 25;
   bit stall_last = 0;

   // ready and read data driven away from the rising edge
   always @(negedge clk) begin
      bus_in <= $urandom;
      if (stall_last && ph == 2 && bt == ln)
         rdy_n <= ($urandom % 8 != 0);
      else
         rdy_n <= (($urandom % 100) < wait_pct);
   end

   task automatic run(input logic [29:0] a, input bit w, input logic [1:0] l, input bit hold);
      @(negedge clk);
      req_addr  = a; req_write = w; req_len = l;
      req_wdata = {$urandom, $urandom, $urandom, $urandom};
      req_valid = 1'b1;
      @(negedge clk);                    // accepted at the edge just passed
      if (!hold) req_valid = 1'b0;
      else begin                         // R2: busy-time request fields change, ignored
         req_addr = ~a; req_len = ~l; req_write = ~w;
      end
      while (ph != 0) @(negedge clk);
      req_valid = 1'b0;
      while (ph != 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      wait_pct = 0;
      run(30'h0000_1234, 1'b0, 2'd0, 0);   // single read, no waits
      run(30'h0ABC_DEF0, 1'b1, 2'd3, 0);   // 4-beat write
      wait_pct = 50;
      run(30'h0000_0010, 1'b0, 2'd2, 0);   // 3-beat read with waits
      run(30'h3FFF_FFFF, 1'b1, 2'd1, 0);   // 2-beat write with waits
      stall_last = 1;
      run(30'h0000_0F00, 1'b1, 2'd3, 0);   // long stall on last beat
      run(30'h0000_0F04, 1'b0, 2'd3, 0);
      stall_last = 0;
      run(30'h0123_4567, 1'b0, 2'd1, 1);   // request held while busy
      repeat (3) @(negedge clk);
      for (int i = 0; i < 300; i++) begin
         wait_pct = int'($urandom % 60);
         run(30'($urandom), 1'($urandom), 2'($urandom), 1'($urandom % 4 == 0));
      end
      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule